// File: doc/BRIEF.md
# Self-Clocked Barcode Station ID Receiver

This block decodes a station number from a single optical line. The line is driven by a comparator and is asynchronous to the system clock. The line rests high. The distance between bars changes with vehicle speed, so the bit period is not known in advance. Each frame therefore opens with a start bit whose low phase lasts half a bit period. The receiver times that low phase and keeps the count. After each of the next eight falling edges it waits for the same count and then samples the line. A bit whose low phase is short reads as 1, and a bit whose low phase is long reads as 0. The first bit received is the most significant.

The raw line passes through a two-flop synchroniser. It then passes through an agreement filter, which changes its output only after three consecutive samples match. All edge detection uses the filtered line.

A completed word is accepted only if its two top bits are zero. When accepted, it is published together with a valid flag. The consumer lowers the flag with a one-cycle clear pulse.

The controller has four states:
- `S_IDLE` waits for a falling edge and then moves to `S_START`.
- `S_START` times the low phase. On the rising edge it moves to `S_GAP` if the phase lasted at least `MIN_START` clocks. Otherwise it returns to `S_IDLE`. It also returns to `S_IDLE` if the timer saturates.
- `S_GAP` waits for the next falling edge and then moves to `S_BIT`. It times out back to `S_IDLE` after twice the stored count or on timer saturation.
- `S_BIT` counts up to the stored value and takes the sample. After the eighth sample it returns to `S_IDLE`; after any earlier sample it returns to `S_GAP`.

Top module: `bcid_rx`

## Requirements
- R1: After reset, `sta_vld` is 0 and `sta_id` is 0x00.
- R2: After each data-bit falling edge the line is sampled once the stored start-low count has elapsed. A high sample gives bit value 1 and a low sample gives bit value 0.
- R3: Bits are received most significant first. Each sample enters bit 0 and earlier bits move toward bit 7.
- R4: `sta_vld` is raised only after all eight bits have arrived and `sta_id[7:6]` equals 2'b00.
- R5: A one-cycle `sta_vld_clr` pulse lowers `sta_vld` on the next clock while no frame is completing. `sta_id` keeps its value.
- R6: A frame whose bits [7:6] are not 2'b00 is discarded. `sta_id` and `sta_vld` keep their previous values.
- R7: Line activity that never holds one level for three consecutive synchronised samples does not affect decoding. An example is 2-high/2-low chatter.
- R8: A start-low phase shorter than `MIN_START` (512) clocks is rejected. The receiver returns to idle, and a following proper frame decodes correctly.
- R9: While waiting for a data-bit falling edge, if twice the stored start count elapses, the receiver returns to idle. A later frame then decodes correctly.
- R10: Frames sent at different bit periods all decode correctly. The timing is learned again from each start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bc_raw | input | 1 | Asynchronous barcode line, idle high |
| sta_id | output | 8 | Last accepted station ID |
| sta_vld | output | 1 | Accepted ID is waiting to be taken |
| sta_vld_clr | input | 1 | Pulse that lowers `sta_vld` |

## Verification
The bench sends IDs whose bit-reversed form fails the integrity check. A receiver that shifted bits the wrong way would raise no valid flag, or would report a different value.

It sends chatter with no three matching samples over the sample point of low bits. Without the filter the receiver would see extra falling edges and lose bit alignment.

It sends a start pulse that is too short, and a lone start bit with no data after it. Without the minimum-length check or the timeout, the receiver would treat the next real start bit as data and decode garbage.

An invalid frame is sent while an earlier ID is still valid. This shows whether a rejected word overwrites the held result.

// File: rtl/bcid_pkg.sv
package bcid_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_START,
        S_GAP,
        S_BIT
    } bcid_state_e;
endpackage

// File: rtl/bcid_filter.sv
module bcid_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int AGREE       = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [AGREE-1:0]       hist_q;
    logic                   filt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            filt_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            hist_q <= {hist_q[AGREE-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q)
                filt_q <= 1'b1;
            else if (~|hist_q)
                filt_q <= 1'b0;
        end
    end

    assign filt_o = filt_q;

    // R7: mixed history leaves the filtered level untouched
    p_glitch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|hist_q) && !(&hist_q)) |=> $stable(filt_q));
endmodule

// File: rtl/bcid_timer.sv
module bcid_timer #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             sat_o
);
    logic [CNT_W-1:0] cnt_q;

    assign sat_o = &cnt_q;
    assign cnt_o = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= '0;
        else if (!sat_o)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/bcid_rx.sv
module bcid_rx #(
    parameter int CNT_W       = 22,
    parameter int ID_W        = 8,
    parameter int CHK_BITS    = 2,
    parameter int MIN_START   = 512,
    parameter int SYNC_STAGES = 2,
    parameter int AGREE       = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bc_raw,
    output logic [ID_W-1:0] sta_id,
    output logic            sta_vld,
    input  logic            sta_vld_clr
);
    import bcid_pkg::*;

    localparam int BC_W = (ID_W > 1) ? $clog2(ID_W) : 1;
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(ID_W - 1);

    bcid_state_e      state_q, state_n;
    logic             filt, filt_d, fall, rise;
    logic [CNT_W-1:0] tcnt, period_q;
    logic             tsat, tclr;
    logic [ID_W-1:0]  shreg_q, shifted;
    logic [BC_W-1:0]  bit_cnt_q;
    logic             too_short, gap_timeout, sample, last, frame_ok;

    bcid_filter #(.SYNC_STAGES(SYNC_STAGES), .AGREE(AGREE)) u_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(bc_raw), .filt_o(filt)
    );

    bcid_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr_i(tclr), .cnt_o(tcnt), .sat_o(tsat)
    );

    assign fall        = filt_d & ~filt;
    assign rise        = ~filt_d & filt;
    assign too_short   = tcnt < CNT_W'(MIN_START);
    assign gap_timeout = tsat || ({1'b0, tcnt} >= {period_q, 1'b0});
    assign sample      = (state_q == S_BIT) && (tcnt == period_q);
    assign last        = bit_cnt_q == LAST_BIT;
    assign shifted     = {shreg_q[ID_W-2:0], filt};
    assign frame_ok    = sample && last && (shifted[ID_W-1 -: CHK_BITS] == '0);
    assign tclr        = (state_n != state_q) || (state_q == S_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE:  if (fall) state_n = S_START;
            S_START: begin
                if (tsat)
                    state_n = S_IDLE;
                else if (rise)
                    state_n = too_short ? S_IDLE : S_GAP;
            end
            S_GAP: begin
                if (fall)
                    state_n = S_BIT;
                else if (gap_timeout)
                    state_n = S_IDLE;
            end
            S_BIT:   if (sample) state_n = last ? S_IDLE : S_GAP;
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_d    <= 1'b1;
            period_q  <= '0;
            shreg_q   <= '0;
            bit_cnt_q <= '0;
            sta_id    <= '0;
            sta_vld   <= 1'b0;
        end else begin
            filt_d <= filt;
            if (state_q == S_START && rise && !too_short) begin
                period_q  <= tcnt;
                bit_cnt_q <= '0;
            end
            if (sample) begin
                shreg_q   <= shifted;
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            if (frame_ok) begin
                sta_id  <= shifted;
                sta_vld <= 1'b1;
            end else if (sta_vld_clr) begin
                sta_vld <= 1'b0;
            end
        end
    end

    // R4: a raised flag always carries a word with clear check bits
    p_vld_top_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sta_vld |-> (sta_id[ID_W-1 -: CHK_BITS] == '0));

    // R5: clear pulse with no completing frame drops the flag
    p_clr_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sta_vld_clr && !frame_ok) |=> !sta_vld);

    // R6: the published ID moves only on an accepted frame
    p_id_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ok |=> $stable(sta_id));

    // R2: bit timer never runs past the learned sample point
    p_bit_timer_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BIT) |-> (tcnt <= period_q));

    // R8: a short start phase sends the controller back to idle
    p_short_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_START && rise && too_short && !tsat) |=> (state_q == S_IDLE));
endmodule

// File: tb/sim_bcid_rx.sv
`timescale 1ns/1ps
module sim_bcid_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bc_raw = 1'b1;
    logic       sta_vld_clr = 1'b0;
    logic [7:0] sta_id;
    logic       sta_vld;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    bcid_rx u0 (
        .clk(clk), .rst_n(rst_n), .bc_raw(bc_raw),
        .sta_id(sta_id), .sta_vld(sta_vld), .sta_vld_clr(sta_vld_clr)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drv(input logic lvl, input int n);
        bc_raw = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] id, input int per, input bit chatter);
        drv(1'b0, per / 2);
        drv(1'b1, per / 2);
        for (int i = 7; i >= 0; i--) begin
            if (id[i]) begin
                drv(1'b0, per / 4);
                drv(1'b1, 3 * per / 4);
            end else if (chatter) begin
                drv(1'b0, per / 8);
                for (int k = 0; k < per / 8; k++) begin
                    drv(1'b1, 2);
                    drv(1'b0, 2);
                end
                drv(1'b0, per / 8);
                drv(1'b1, per / 4);
            end else begin
                drv(1'b0, 3 * per / 4);
                drv(1'b1, per / 4);
            end
        end
        drv(1'b1, 50);
    endtask

    task automatic pulse_clr();
        sta_vld_clr = 1'b1;
        @(negedge clk);
        sta_vld_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk({7'd0, sta_vld}, 8'h00, "R1 vld after reset");
        chk(sta_id, 8'h00, "R1 id after reset");
    endtask

    task automatic t_basic();
        send_frame(8'h2A, 1200, 1'b0);
        chk({7'd0, sta_vld}, 8'h01, "R2 vld after frame");
        chk(sta_id, 8'h2A, "R3 msb-first id");
    endtask

    task automatic t_clear();
        pulse_clr();
        chk({7'd0, sta_vld}, 8'h00, "R5 vld cleared");
        chk(sta_id, 8'h2A, "R5 id kept on clear");
    endtask

    task automatic t_speed();
        send_frame(8'h13, 2000, 1'b0);
        chk({7'd0, sta_vld}, 8'h01, "R10 vld at slow period");
        chk(sta_id, 8'h13, "R10 id at slow period");
    endtask

    task automatic t_invalid();
        send_frame(8'h93, 1400, 1'b0);
        chk({7'd0, sta_vld}, 8'h01, "R6 vld kept after bad frame");
        chk(sta_id, 8'h13, "R6 id kept after bad frame");
        pulse_clr();
        send_frame(8'h40, 1400, 1'b0);
        chk({7'd0, sta_vld}, 8'h00, "R4 no vld for top bits 01");
        chk(sta_id, 8'h13, "R4 id kept for top bits 01");
    endtask

    task automatic t_chatter();
        send_frame(8'h05, 1600, 1'b1);
        chk({7'd0, sta_vld}, 8'h01, "R7 vld with chatter");
        chk(sta_id, 8'h05, "R7 id with chatter");
        pulse_clr();
    endtask

    task automatic t_short_start();
        drv(1'b0, 300);
        drv(1'b1, 1000);
        chk({7'd0, sta_vld}, 8'h00, "R8 no vld after short start");
        send_frame(8'h21, 1200, 1'b0);
        chk({7'd0, sta_vld}, 8'h01, "R8 vld after recovery");
        chk(sta_id, 8'h21, "R8 id after recovery");
        pulse_clr();
    endtask

    task automatic t_timeout();
        drv(1'b0, 700);
        drv(1'b1, 3000);
        chk({7'd0, sta_vld}, 8'h00, "R9 no vld after lone start");
        send_frame(8'h36, 1200, 1'b0);
        chk({7'd0, sta_vld}, 8'h01, "R9 vld after timeout");
        chk(sta_id, 8'h36, "R9 id after timeout");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_basic();
        t_clear();
        t_speed();
        t_invalid();
        t_chatter();
        t_short_start();
        t_timeout();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule